// File: doc/BRIEF.md
# GPIO Controller with Interrupts

A word-addressed general-purpose I/O block for up to 32 pins. Software sets each pin as an input or an output through a direction register. Output pins drive the level held in the value register. Reading the value register returns the synchronized pad level of input pins and the driven level of output pins. Pad inputs pass through a two-flop synchronizer, and a third flop keeps the previous sample for edge detection.

Each pin has three configuration bits, one in each of three separate registers:
- a mode bit chooses level or edge triggering;
- a polarity bit chooses high/rising or low/falling;
- a dual-edge bit, together with edge mode, makes any transition trigger.

A triggered pin sets a sticky status bit. The enable register masks status into the pending register. The single interrupt line is the OR of all pending bits. Status bits are cleared by writing ones to the clear register. A read-only version register reports 3, the first revision with the dual-edge register.

Register word offsets:

| Offset | Register |
|--------|----------|
| 0x00 | value |
| 0x04 | direction |
| 0x08 | enable |
| 0x0C | status |
| 0x10 | pending |
| 0x14 | clear |
| 0x18 | mode |
| 0x1C | polarity |
| 0x20 | version |
| 0x24 | dual-edge |

Top module: `gpio_irq_ctrl`

## Requirements
- R1: The version word at offset 0x20 reads 3 and ignores writes. Offsets that are unmapped or not word-aligned read 0. Writes to the status (0x0C) and pending (0x10) words are ignored.
- R2: Direction bit 1 makes the pin an input, with pinOe low. Direction bit 0 makes it an output, with pinOe high, and pinOut carries the value-register bit.
- R3: A value read returns, for input pins, the pad level seen through the two synchronizer flops. For output pins it returns the value-register bit.
- R4: With mode bit 0 (level), the pin sets its status bit on every cycle that the synchronized level matches the polarity bit (1 = high, 0 = low).
- R5: With mode bit 1 (edge) and dual-edge bit 0, a rising edge triggers when polarity is 1 and a falling edge triggers when polarity is 0.
- R6: With both mode bit and dual-edge bit at 1, every transition triggers whatever the polarity bit holds. A dual-edge bit with mode bit 0 leaves level behaviour unchanged.
- R7: Status bits are sticky and independent of enable. Writing 1 to a clear-word bit clears it, and writing 0 has no effect. A trigger in the same cycle as its clear leaves the bit set, so a still-active level pin stays set.
- R8: The pending word equals status AND enable.
- R9: irqOut is high exactly when any pending bit is set.
- R10: Register bits at and above NUM_PINS read 0, and writes to them are ignored.
- R11: After reset:
  - direction is all ones;
  - polarity is all ones;
  - value, enable, mode, dual-edge and status are zero;
  - irqOut is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the register word |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data (combinational from address) |
| pinIn | input | NUM_PINS | Pad input levels (asynchronous) |
| pinOut | output | NUM_PINS | Output drive levels |
| pinOe | output | NUM_PINS | Output enables, 1 = driving |
| irqOut | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a trigger that falls in exactly the same cycle as a clear write to its own bit. The pad change must lead the bus write by the synchronizer depth plus the edge register. The bench drives an edge-mode pin one negative edge before the clear write begins, so that the event and the clear are both captured on the same clock edge. A level pin that is cleared while still active covers the same rule continuously. Random pad toggles, interleaved with random writes to the mode, polarity and dual-edge words, also reach mode changes on pins that are mid-transition.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Word indices (byte offset / 4) of the register map
  localparam int unsigned WORD_VALUE = 0;
  localparam int unsigned WORD_DIR   = 1;
  localparam int unsigned WORD_IEN   = 2;
  localparam int unsigned WORD_STAT  = 3;
  localparam int unsigned WORD_PEND  = 4;
  localparam int unsigned WORD_CLR   = 5;
  localparam int unsigned WORD_MODE  = 6;
  localparam int unsigned WORD_POL   = 7;
  localparam int unsigned WORD_VER   = 8;
  localparam int unsigned WORD_DUAL  = 9;

  // Write strobes from control to datapath
  typedef struct packed {
    logic value;
    logic dir;
    logic ien;
    logic clr;
    logic mode;
    logic pol;
    logic dual;
  } wrStrobe_t;

  typedef enum logic [3:0] {
    RS_VALUE, RS_DIR, RS_IEN, RS_STAT, RS_PEND,
    RS_MODE, RS_POL, RS_VER, RS_DUAL, RS_NONE
  } rdSel_t;

endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output wrStrobe_t         stb,
  output rdSel_t            rdSel
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             doWrite;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign doWrite = busSel && busWe && aligned;

  always_comb begin
    stb = '0;
    if (doWrite) begin
      case (int'(wordIdx))
        WORD_VALUE: stb.value = 1'b1;
        WORD_DIR:   stb.dir   = 1'b1;
        WORD_IEN:   stb.ien   = 1'b1;
        WORD_CLR:   stb.clr   = 1'b1;
        WORD_MODE:  stb.mode  = 1'b1;
        WORD_POL:   stb.pol   = 1'b1;
        WORD_DUAL:  stb.dual  = 1'b1;
        default:    stb       = '0;
      endcase
    end
  end

  always_comb begin
    rdSel = RS_NONE;
    if (aligned) begin
      case (int'(wordIdx))
        WORD_VALUE: rdSel = RS_VALUE;
        WORD_DIR:   rdSel = RS_DIR;
        WORD_IEN:   rdSel = RS_IEN;
        WORD_STAT:  rdSel = RS_STAT;
        WORD_PEND:  rdSel = RS_PEND;
        WORD_MODE:  rdSel = RS_MODE;
        WORD_POL:   rdSel = RS_POL;
        WORD_VER:   rdSel = RS_VER;
        WORD_DUAL:  rdSel = RS_DUAL;
        default:    rdSel = RS_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int VERSION  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  wrStrobe_t           stb,
  input  logic [NUM_PINS-1:0] wrData,
  input  rdSel_t              rdSel,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [31:0]         rdData,
  output logic                irqOut
);

  logic [NUM_PINS-1:0] valQ, dirQ, ienQ, modeQ, polQ, dualQ, statQ;
  logic [NUM_PINS-1:0] sync1Q, sync2Q, prevQ;
  logic [NUM_PINS-1:0] trig, clrMask, pendV, readVal;

  // Configuration registers and input synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valQ   <= '0;
      dirQ   <= '1;
      ienQ   <= '0;
      modeQ  <= '0;
      polQ   <= '1;
      dualQ  <= '0;
      sync1Q <= '0;
      sync2Q <= '0;
      prevQ  <= '0;
    end else begin
      sync1Q <= pinIn;
      sync2Q <= sync1Q;
      prevQ  <= sync2Q;
      if (stb.value) valQ  <= wrData;
      if (stb.dir)   dirQ  <= wrData;
      if (stb.ien)   ienQ  <= wrData;
      if (stb.mode)  modeQ <= wrData;
      if (stb.pol)   polQ  <= wrData;
      if (stb.dual)  dualQ <= wrData;
    end
  end

  // Per-pin trigger selection
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic rise, fall, lvlHit, edgeHit;
    assign rise    = sync2Q[g] & ~prevQ[g];
    assign fall    = ~sync2Q[g] & prevQ[g];
    assign lvlHit  = polQ[g] ? sync2Q[g] : ~sync2Q[g];
    assign edgeHit = dualQ[g] ? (rise | fall) : (polQ[g] ? rise : fall);
    assign trig[g] = modeQ[g] ? edgeHit : lvlHit;
  end

  // Sticky status: new trigger wins over a same-cycle clear
  assign clrMask = stb.clr ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~clrMask) | trig;
  end

  assign pendV   = statQ & ienQ;
  assign irqOut  = |pendV;
  assign pinOut  = valQ;
  assign pinOe   = ~dirQ;
  assign readVal = (dirQ & sync2Q) | (~dirQ & valQ);

  always_comb begin
    rdData = '0;
    case (rdSel)
      RS_VALUE: rdData[NUM_PINS-1:0] = readVal;
      RS_DIR:   rdData[NUM_PINS-1:0] = dirQ;
      RS_IEN:   rdData[NUM_PINS-1:0] = ienQ;
      RS_STAT:  rdData[NUM_PINS-1:0] = statQ;
      RS_PEND:  rdData[NUM_PINS-1:0] = pendV;
      RS_MODE:  rdData[NUM_PINS-1:0] = modeQ;
      RS_POL:   rdData[NUM_PINS-1:0] = polQ;
      RS_DUAL:  rdData[NUM_PINS-1:0] = dualQ;
      RS_VER:   rdData = 32'(VERSION);
      default:  rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6,
  parameter int VERSION  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [31:0]         busWrData,
  output logic [31:0]         busRdData,
  input  logic [NUM_PINS-1:0] pinIn,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinOe,
  output logic                irqOut
);

  wrStrobe_t stb;
  rdSel_t    rdSel;

  if (NUM_PINS < 32) begin : g_hi
    logic unusedHiBits;
    assign unusedHiBits = ^busWrData[31:NUM_PINS];
  end

  gpio_irq_decode #(.ADDR_W(ADDR_W)) u_dec (
    .busSel (busSel),
    .busWe  (busWe),
    .busAddr(busAddr),
    .stb    (stb),
    .rdSel  (rdSel)
  );

  gpio_irq_dp #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .wrData(busWrData[NUM_PINS-1:0]),
    .rdSel (rdSel),
    .pinIn (pinIn),
    .pinOut(pinOut),
    .pinOe (pinOe),
    .rdData(busRdData),
    .irqOut(irqOut)
  );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 6,
  parameter int VERSION  = 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busWe,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [31:0]         busWrData,
  input logic [31:0]         busRdData,
  input logic [NUM_PINS-1:0] pinOe,
  input logic                irqOut,
  input logic [NUM_PINS-1:0] statQ,
  input logic [NUM_PINS-1:0] ienQ
);

  logic                isRead, dirWrite;
  logic [NUM_PINS-1:0] clrSeen;

  assign isRead   = busSel && !busWe;
  assign dirWrite = busSel && busWe && (busAddr == ADDR_W'(6'h04));
  assign clrSeen  = (busSel && busWe && (busAddr == ADDR_W'(6'h14)))
                    ? busWrData[NUM_PINS-1:0] : '0;

  AST_VERSION_READ: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && busAddr == ADDR_W'(6'h20)) |-> busRdData == 32'(VERSION)); // R1

  AST_OE_FROM_DIR: assert property (@(posedge clk) disable iff (!rstN)
    dirWrite |=> pinOe == ~$past(busWrData[NUM_PINS-1:0])); // R2

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (|statQ) |=> ((($past(statQ) & ~$past(clrSeen)) & ~statQ) == '0)); // R7

  AST_PEND_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && busAddr == ADDR_W'(6'h10))
      |-> busRdData[NUM_PINS-1:0] == (statQ & ienQ)); // R8

  AST_IRQ_ANY: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (|(statQ & ienQ))); // R9

  if (NUM_PINS < 32) begin : g_hiChk
    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (isRead && busAddr != ADDR_W'(6'h20)) |-> busRdData[31:NUM_PINS] == '0); // R10
  end

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .VERSION(VERSION)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busSel   (busSel),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .pinOe    (pinOe),
  .irqOut   (irqOut),
  .statQ    (u_dp.statQ),
  .ienQ     (u_dp.ienQ)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;

  localparam int N  = 20;
  localparam int AW = 6;
  localparam logic [N-1:0] ALL = '1;

  localparam logic [AW-1:0] A_VAL  = 6'h00, A_DIR  = 6'h04, A_IEN = 6'h08,
                            A_STAT = 6'h0C, A_PEND = 6'h10, A_CLR = 6'h14,
                            A_MODE = 6'h18, A_POL  = 6'h1C, A_VER = 6'h20,
                            A_DUAL = 6'h24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0, busWe = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [31:0]   busWrData = '0;
  logic [31:0]   busRdData;
  logic [N-1:0]  pinIn = '0;
  logic [N-1:0]  pinOut, pinOe;
  logic          irqOut;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(N), .ADDR_W(AW), .VERSION(3)) dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqOut(irqOut)
  );

  // Reference model built from the requirements
  logic [N-1:0] m1, m2, m3, mVal, mDir, mIen, mMode, mPol, mDual, mStat;

  function automatic logic [N-1:0] modelTrig(input logic [N-1:0] cur, prv,
      mode, pol, dual);
    logic [N-1:0] t;
    for (int i = 0; i < N; i++) begin
      if (!mode[i])     t[i] = pol[i] ? cur[i] : ~cur[i];
      else if (dual[i]) t[i] = cur[i] ^ prv[i];
      else if (pol[i])  t[i] = cur[i] & ~prv[i];
      else              t[i] = ~cur[i] & prv[i];
    end
    return t;
  endfunction

  function automatic logic [31:0] modelRead(input logic [AW-1:0] a);
    logic [N-1:0] v;
    v = '0;
    case (a)
      A_VAL:  v = (mDir & m2) | (~mDir & mVal);
      A_DIR:  v = mDir;
      A_IEN:  v = mIen;
      A_STAT: v = mStat;
      A_PEND: v = mStat & mIen;
      A_MODE: v = mMode;
      A_POL:  v = mPol;
      A_DUAL: v = mDual;
      A_VER:  return 32'd3;
      default: v = '0;
    endcase
    return 32'(v);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      m1 <= '0; m2 <= '0; m3 <= '0;
      mVal <= '0; mDir <= ALL; mIen <= '0; mMode <= '0;
      mPol <= ALL; mDual <= '0; mStat <= '0;
    end else begin
      logic [N-1:0] clr;
      clr = '0;
      m1 <= pinIn; m2 <= m1; m3 <= m2;
      if (busSel && busWe) begin
        case (busAddr)
          A_VAL:  mVal  <= busWrData[N-1:0];
          A_DIR:  mDir  <= busWrData[N-1:0];
          A_IEN:  mIen  <= busWrData[N-1:0];
          A_MODE: mMode <= busWrData[N-1:0];
          A_POL:  mPol  <= busWrData[N-1:0];
          A_DUAL: mDual <= busWrData[N-1:0];
          A_CLR:  clr    = busWrData[N-1:0];
          default: ;
        endcase
      end
      mStat <= (mStat & ~clr) | modelTrig(m2, m3, mMode, mPol, mDual);
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWe = 1'b0; busAddr = a;
    #1 d = busRdData;
    busSel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setPin(input int p, input logic v);
    @(negedge clk);
    pinIn[p] = v;
  endtask

  logic [31:0] rd;

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R11 reset state, R1 version, R2 all inputs
    busRead(A_DIR, rd);  check("R11 dir", rd, 32'h000F_FFFF);
    busRead(A_POL, rd);  check("R11 pol", rd, 32'h000F_FFFF);
    busRead(A_IEN, rd);  check("R11 ien", rd, 32'h0);
    busRead(A_STAT, rd); check("R11 stat", rd, 32'h0);
    check("R11 irq", {31'd0, irqOut}, 32'd0);
    check("R2 oe reset", 32'(pinOe), 32'h0);
    busRead(A_VER, rd);  check("R1 version", rd, 32'd3);
    busWrite(A_VER, 32'hFF);
    busRead(A_VER, rd);  check("R1 version ro", rd, 32'd3);
    busRead(6'h2C, rd);  check("R1 unmapped", rd, 32'h0);
    busRead(6'h05, rd);  check("R1 unaligned", rd, 32'h0);

    // R10 high bits
    busWrite(A_MODE, 32'hFFFF_FFFF);
    busRead(A_MODE, rd); check("R10 mode high bits", rd, 32'h000F_FFFF);
    busWrite(A_MODE, 32'h0);

    // R2 / R3 output drive and readback
    busWrite(A_DIR, 32'h000F_FFFE);
    busWrite(A_VAL, 32'h1);
    check("R2 pinOut", 32'(pinOut[0]), 32'd1);
    check("R2 pinOe", 32'(pinOe), 32'h1);
    setPin(5, 1'b1);
    idle(3);
    busRead(A_VAL, rd); check("R3 value read", rd, 32'h21);

    // R4 level high latched, R7 without enable, R8 pending masked
    busRead(A_STAT, rd); check("R4 level high", rd & 32'h20, 32'h20);
    busRead(A_PEND, rd); check("R8 pend masked", rd, 32'h0);
    check("R9 irq low", {31'd0, irqOut}, 32'd0);
    busWrite(A_CLR, 32'h20);
    busRead(A_STAT, rd); check("R7 active level relatches", rd & 32'h20, 32'h20);
    setPin(5, 1'b0);
    idle(3);
    busWrite(A_CLR, 32'h20);
    busRead(A_STAT, rd); check("R7 cleared", rd & 32'h20, 32'h0);

    // R4 level low on pin 6 (pin stays 0)
    busWrite(A_POL, 32'h000F_FFBF);
    idle(2);
    busRead(A_STAT, rd); check("R4 level low", rd & 32'h40, 32'h40);
    busWrite(A_POL, 32'h000F_FFFF);
    idle(1);
    busWrite(A_CLR, 32'h40);
    busRead(A_STAT, rd); check("R4 low cleared", rd & 32'h40, 32'h0);

    // R5 rising edge on pin 7
    busWrite(A_MODE, 32'h80);
    setPin(7, 1'b1);
    idle(4);
    busRead(A_STAT, rd); check("R5 rising", rd & 32'h80, 32'h80);
    busWrite(A_CLR, 32'h80);
    setPin(7, 1'b0);
    idle(4);
    busRead(A_STAT, rd); check("R5 falling ignored", rd & 32'h80, 32'h0);
    busWrite(A_POL, 32'h000F_FF7F);
    setPin(7, 1'b1);
    idle(4);
    busRead(A_STAT, rd); check("R5 rise ignored", rd & 32'h80, 32'h0);
    setPin(7, 1'b0);
    idle(4);
    busRead(A_STAT, rd); check("R5 falling", rd & 32'h80, 32'h80);

    // R8 / R9 pending and irq; R7 zero write no effect
    busWrite(A_IEN, 32'h80);
    busRead(A_PEND, rd); check("R8 pending", rd, 32'h80);
    check("R9 irq high", {31'd0, irqOut}, 32'd1);
    busWrite(A_CLR, 32'h0);
    busRead(A_STAT, rd); check("R7 zero write", rd & 32'h80, 32'h80);

    // R7 same-cycle trigger and clear: rise on pin 7 meets clear
    busWrite(A_POL, 32'h000F_FFFF);
    setPin(7, 1'b1);
    @(negedge clk);
    busWrite(A_CLR, 32'h80);
    busRead(A_STAT, rd); check("R7 set wins", rd & 32'h80, 32'h80);
    busWrite(A_CLR, 32'h80);
    check("R9 irq cleared", {31'd0, irqOut}, 32'd0);
    busWrite(A_IEN, 32'h0);

    // R6 dual edge on pin 8, polarity ignored
    busWrite(A_MODE, 32'h180);
    busWrite(A_DUAL, 32'h300);
    busWrite(A_POL, 32'h000F_FEFF);
    setPin(8, 1'b1);
    idle(4);
    busRead(A_STAT, rd); check("R6 dual rise", rd & 32'h100, 32'h100);
    busWrite(A_CLR, 32'h100);
    setPin(8, 1'b0);
    idle(4);
    busRead(A_STAT, rd); check("R6 dual fall", rd & 32'h100, 32'h100);
    // pin 9: dual bit with level mode behaves as level high
    busWrite(A_POL, 32'h000F_FFFF);
    setPin(9, 1'b1);
    idle(4);
    busRead(A_STAT, rd); check("R6 dual in level mode", rd & 32'h200, 32'h200);
    setPin(9, 1'b0);
    idle(4);
    busWrite(A_CLR, 32'h300);
    idle(2);
    busRead(A_STAT, rd); check("R6 no fall in level mode", rd & 32'h200, 32'h0);

    // Random phase against the model
    for (int it = 0; it < 400; it++) begin
      logic [AW-1:0] a;
      int op;
      @(negedge clk);
      pinIn = pinIn ^ N'($urandom & $urandom);
      op = int'($urandom % 10);
      a  = {4'($urandom % 12), 2'b00};
      if (op < 5) busWrite(a, $urandom);
      else if (op < 7) busWrite(A_CLR, $urandom);
      idle(int'($urandom % 3));
      busRead(a, rd);
      check("R4 R5 R6 R7 random read", rd, modelRead(a));
      busRead(A_STAT, rd);
      check("R7 random status", rd, modelRead(A_STAT));
      check("R9 random irq", {31'd0, irqOut}, {31'd0, |(mStat & mIen)});
      check("R2 random drive", {pinOe, pinOut}, {~mDir, mVal});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule